// File: doc/BRIEF.md
# Configuration Port Host Bridge

This block sits between a 32-bit host register bus and an internal configuration port. The host loads configuration words one at a time into a write FIFO, then sets a start bit that drains the FIFO onto the port through a valid/ready pair. The host can also program a word count and start a readback. The block then accepts that many words from the port through a second valid/ready pair and stores them in a read FIFO, which the host empties by reading a data register.

The host sees status, write-FIFO vacancy and read-FIFO occupancy through registers. It can therefore size its bursts without overrunning the FIFO and poll for completion. A sticky overflow flag records pushes that were dropped. The interrupt output is that flag masked by a per-source enable and a global enable.

Top module: `cfgport_bridge`

## Requirements
- R1: After reset, with the startup pin low, the status register (0x110) reads 0x1, vacancy (0x114) reads the write-FIFO depth, occupancy (0x118) reads 0, control (0x10C) reads 0 and `irq` is low.
- R2: Each host write to 0x100 pushes one word into the write FIFO. The vacancy register reports the free entries. No word reaches the port before a drain is started.
- R3: A push into a full write FIFO is dropped and sets bit 0 of the interrupt status register (0x20). Writing 1 to that bit clears it.
- R4: Writing 1 to control bit 0 starts a drain. Words leave on `cfg_out_*` in push order. Control bit 0 reads 1 until the FIFO is empty, then reads 0.
- R5: While `cfg_out_valid` is high and `cfg_out_ready` is low, valid and data hold steady.
- R6: Writing 1 to control bit 1 starts a readback of the word count held in the size register (0x108). Control bit 1 reads 1 until all of those words have been taken, then reads 0. The size register reads back what was written.
- R7: A readback stalls (`cfg_in_ready` low) while the read FIFO is full. It resumes once the host pops words.
- R8: A host read of 0x104 returns and pops the oldest read-FIFO word. When the FIFO is empty it returns 0 and pops nothing.
- R9: Status bit 0 is clear while a drain or a readback runs. Status bit 2 mirrors the `startup_done` pin.
- R10: `irq` is high only when global enable bit 0 (0x1C), interrupt enable bit 0 (0x28) and the overflow flag are all set. Writing 0 to 0x1C masks it.
- R11: The abort status register (0x11C) reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (pops on 0x104) |
| reg_addr | input | ADDR_W | Host byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from address |
| irq | output | 1 | Masked overflow interrupt |
| startup_done | input | 1 | End-of-startup indication from the port |
| cfg_out_data | output | 32 | Word toward the configuration port |
| cfg_out_valid | output | 1 | Outgoing word valid |
| cfg_out_ready | input | 1 | Port accepts outgoing word |
| cfg_in_data | input | 32 | Readback word from the port |
| cfg_in_valid | input | 1 | Readback word valid |
| cfg_in_ready | output | 1 | Block accepts readback word |

## Verification
The bench builds the block with an 8-entry write FIFO and a 4-entry read FIFO. With these sizes the overflow drop takes only nine pushes. A six-word readback overruns the read FIFO, so the stall and its resume after host pops are exercised. Back-pressure on the output port is held for several cycles to observe the hold behaviour and the busy status together.

// File: rtl/cfgport_bridge.sv
module cfgport_bridge #(
  parameter int WDEPTH = 16,
  parameter int RDEPTH = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  input  logic              startup_done,
  output logic [31:0]       cfg_out_data,
  output logic              cfg_out_valid,
  input  logic              cfg_out_ready,
  input  logic [31:0]       cfg_in_data,
  input  logic              cfg_in_valid,
  output logic              cfg_in_ready
);
  localparam int WAW = $clog2(WDEPTH);
  localparam int RAW = $clog2(RDEPTH);
  localparam logic [WAW:0]   WFULL = (WAW+1)'(WDEPTH);
  localparam logic [RAW:0]   RFULL = (RAW+1)'(RDEPTH);
  localparam logic [WAW:0]   WC1 = 1;
  localparam logic [RAW:0]   RC1 = 1;
  localparam logic [WAW-1:0] WP1 = 1;
  localparam logic [RAW-1:0] RP1 = 1;
  localparam logic [ADDR_W-1:0] A_GEN = ADDR_W'(12'h01C);
  localparam logic [ADDR_W-1:0] A_IST = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(12'h028);
  localparam logic [ADDR_W-1:0] A_WDAT = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] A_RDAT = ADDR_W'(12'h104);
  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(12'h108);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(12'h10C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12'h110);
  localparam logic [ADDR_W-1:0] A_VAC = ADDR_W'(12'h114);
  localparam logic [ADDR_W-1:0] A_OCC = ADDR_W'(12'h118);

  logic [31:0]    wmem [WDEPTH];
  logic [31:0]    rmem [RDEPTH];
  logic [WAW-1:0] whead, wtail;
  logic [RAW-1:0] rhead, rtail;
  logic [WAW:0]   wcount;
  logic [RAW:0]   rcount;
  logic           wr_busy, rd_busy, gie, ier, ovf;
  logic [31:0]    size_q, rd_left;

  wire wr_data_hit = reg_wr && reg_addr == A_WDAT;
  wire ctl_hit     = reg_wr && reg_addr == A_CTL;
  wire push_w      = wr_data_hit && wcount != WFULL;
  wire drop_w      = wr_data_hit && wcount == WFULL;
  wire pop_r       = reg_rd && reg_addr == A_RDAT && rcount != 0;
  wire out_fire    = cfg_out_valid && cfg_out_ready;
  wire in_fire     = cfg_in_valid && cfg_in_ready;

  assign cfg_out_valid = wr_busy && wcount != 0;
  assign cfg_out_data  = wmem[whead];
  assign cfg_in_ready  = rd_busy && rd_left != 0 && rcount != RFULL;
  assign irq           = gie && ier && ovf;

  always_ff @(posedge clk) begin
    if (push_w) wmem[wtail] <= reg_wdata;
    if (in_fire) rmem[rtail] <= cfg_in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      whead <= '0; wtail <= '0; wcount <= '0;
      rhead <= '0; rtail <= '0; rcount <= '0;
    end else begin
      if (push_w) wtail <= wtail + WP1;
      if (out_fire) whead <= whead + WP1;
      case ({push_w, out_fire})
        2'b10: wcount <= wcount + WC1;
        2'b01: wcount <= wcount - WC1;
        default: ;
      endcase
      if (in_fire) rtail <= rtail + RP1;
      if (pop_r) rhead <= rhead + RP1;
      case ({in_fire, pop_r})
        2'b10: rcount <= rcount + RC1;
        2'b01: rcount <= rcount - RC1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_busy <= 1'b0; rd_busy <= 1'b0; rd_left <= '0;
      size_q <= '0; gie <= 1'b0; ier <= 1'b0; ovf <= 1'b0;
    end else begin
      if (wr_busy && wcount == 0) wr_busy <= 1'b0;
      else if (ctl_hit && reg_wdata[0]) wr_busy <= 1'b1;
      if (rd_busy && rd_left == 0) rd_busy <= 1'b0;
      else if (ctl_hit && reg_wdata[1] && !rd_busy) begin
        rd_busy <= 1'b1;
        rd_left <= size_q;
      end else if (in_fire) rd_left <= rd_left - 32'd1;
      if (reg_wr && reg_addr == A_SIZE) size_q <= reg_wdata;
      if (reg_wr && reg_addr == A_GEN) gie <= reg_wdata[0];
      if (reg_wr && reg_addr == A_IEN) ier <= reg_wdata[0];
      if (drop_w) ovf <= 1'b1;
      else if (reg_wr && reg_addr == A_IST && reg_wdata[0]) ovf <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_GEN:  reg_rdata = {31'b0, gie};
      A_IST:  reg_rdata = {31'b0, ovf};
      A_IEN:  reg_rdata = {31'b0, ier};
      A_RDAT: reg_rdata = (rcount != 0) ? rmem[rhead] : 32'b0;
      A_SIZE: reg_rdata = size_q;
      A_CTL:  reg_rdata = {30'b0, rd_busy, wr_busy};
      A_STAT: reg_rdata = {29'b0, startup_done, 1'b0, !(wr_busy || rd_busy)};
      A_VAC:  reg_rdata = 32'(WDEPTH) - 32'(wcount);
      A_OCC:  reg_rdata = 32'(rcount);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfgport_bridge_chk.sv
module cfgport_bridge_chk #(
  parameter int WDEPTH = 16,
  parameter int RDEPTH = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              irq,
  input logic              cfg_out_valid,
  input logic              cfg_out_ready,
  input logic [31:0]       cfg_out_data,
  input logic              cfg_in_ready,
  input logic              wr_busy,
  input logic              rd_busy,
  input logic              gie,
  input logic              ier,
  input logic              ovf,
  input logic [$clog2(WDEPTH):0] wcount,
  input logic [$clog2(RDEPTH):0] rcount
);
  p_valid_in_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out_valid |-> wr_busy);

  p_hold_under_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_out_valid && !cfg_out_ready |=> cfg_out_valid && $stable(cfg_out_data));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_W'(12'h100) && 32'(wcount) == WDEPTH |=> ovf);

  p_no_rd_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_in_ready |-> 32'(rcount) < RDEPTH);

  p_busy_clears_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == ADDR_W'(12'h110) && (wr_busy || rd_busy) |-> !reg_rdata[0]);

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> gie && ier);
endmodule

bind cfgport_bridge cfgport_bridge_chk #(.WDEPTH(WDEPTH), .RDEPTH(RDEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq(irq), .cfg_out_valid(cfg_out_valid),
  .cfg_out_ready(cfg_out_ready), .cfg_out_data(cfg_out_data), .cfg_in_ready(cfg_in_ready),
  .wr_busy(wr_busy), .rd_busy(rd_busy), .gie(gie), .ier(ier), .ovf(ovf),
  .wcount(wcount), .rcount(rcount)
);

// File: tb/sim_cfgport_bridge.sv
module sim_cfgport_bridge;
  localparam int WD = 8;
  localparam int RD = 4;
  localparam logic [11:0] GEN = 12'h01C, IST = 12'h020, IEN = 12'h028, WDAT = 12'h100,
    RDAT = 12'h104, SIZE = 12'h108, CTL = 12'h10C, STAT = 12'h110, VAC = 12'h114,
    OCC = 12'h118, ABRT = 12'h11C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, startup_done = 1'b0;
  logic [31:0] cfg_out_data, cfg_in_data;
  logic cfg_out_valid, cfg_out_ready = 1'b0, cfg_in_valid = 1'b0, cfg_in_ready;

  cfgport_bridge #(.WDEPTH(WD), .RDEPTH(RD), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .startup_done(startup_done),
    .cfg_out_data(cfg_out_data), .cfg_out_valid(cfg_out_valid), .cfg_out_ready(cfg_out_ready),
    .cfg_in_data(cfg_in_data), .cfg_in_valid(cfg_in_valid), .cfg_in_ready(cfg_in_ready)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] out_log [64];
  int out_n = 0;
  int in_idx = 0;
  bit in_pend = 0;
  int exp_k = 0;

  assign cfg_in_data = 32'hC0DE_0000 + 32'(in_idx);

  always @(negedge clk) begin
    if (in_pend) in_idx++;
    in_pend = 0;
    #2;
    if (cfg_in_valid && cfg_in_ready) in_pend = 1;
    if (cfg_out_valid && cfg_out_ready && out_n < 64) begin
      out_log[out_n] = cfg_out_data;
      out_n++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_idle(logic [31:0] mask, string req);
    logic [31:0] v;
    v = mask;
    for (int i = 0; i < 200 && (v & mask) != 0; i++) rd(CTL, v);
    check(req, v & mask, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(STAT, v); check("R1 status", v, 32'h1);
    rd(VAC, v);  check("R1 vacancy", v, WD);
    rd(OCC, v);  check("R1 occupancy", v, 0);
    rd(CTL, v);  check("R1 control", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    rd(ABRT, v); check("R11 abort", v, 0);
  endtask

  task automatic t_push_drain();
    logic [31:0] v;
    int n0;
    cfg_out_ready = 1'b1;
    for (int i = 0; i < 3; i++) wr(WDAT, 32'hA000_0000 + 32'(i));
    rd(VAC, v); check("R2 vacancy", v, WD - 3);
    check("R2 no output before start", {31'b0, cfg_out_valid}, 0);
    n0 = out_n;
    wr(CTL, 32'h1);
    rd(CTL, v); check("R4 busy bit", v & 1, 1);
    wait_idle(1, "R4 done");
    check("R4 count", 32'(out_n - n0), 3);
    for (int i = 0; i < 3; i++) check("R4 order", out_log[n0 + i], 32'hA000_0000 + 32'(i));
    rd(VAC, v); check("R2 vacancy restored", v, WD);
  endtask

  task automatic t_backpressure();
    logic [31:0] v;
    int n0;
    cfg_out_ready = 1'b0;
    wr(WDAT, 32'h5555_0001);
    wr(WDAT, 32'h5555_0002);
    n0 = out_n;
    wr(CTL, 32'h1);
    repeat (4) @(negedge clk);
    check("R5 valid held", {31'b0, cfg_out_valid}, 1);
    check("R5 data held", cfg_out_data, 32'h5555_0001);
    rd(CTL, v); check("R4 busy under stall", v & 1, 1);
    rd(STAT, v); check("R9 idle clear", v, 0);
    cfg_out_ready = 1'b1;
    wait_idle(1, "R4 done after stall");
    check("R5 word0", out_log[n0], 32'h5555_0001);
    check("R5 word1", out_log[n0 + 1], 32'h5555_0002);
    rd(STAT, v); check("R9 idle set", v, 32'h1);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    int n0;
    cfg_out_ready = 1'b0;
    for (int i = 0; i < WD + 1; i++) wr(WDAT, 32'hB000_0000 + 32'(i));
    rd(VAC, v); check("R2 vacancy full", v, 0);
    rd(IST, v); check("R3 overflow flag", v, 1);
    check("R10 irq masked", {31'b0, irq}, 0);
    wr(IEN, 1); wr(GEN, 1);
    check("R10 irq raised", {31'b0, irq}, 1);
    wr(GEN, 0);
    check("R10 global mask", {31'b0, irq}, 0);
    wr(IST, 1);
    rd(IST, v); check("R3 flag cleared", v, 0);
    cfg_out_ready = 1'b1;
    n0 = out_n;
    wr(CTL, 32'h1);
    wait_idle(1, "R4 done full");
    check("R3 dropped push", 32'(out_n - n0), WD);
    for (int i = 0; i < WD; i++) check("R3 kept words", out_log[n0 + i], 32'hB000_0000 + 32'(i));
  endtask

  task automatic t_readback();
    logic [31:0] v;
    cfg_in_valid = 1'b1;
    wr(SIZE, 3);
    rd(SIZE, v); check("R6 size readback", v, 3);
    wr(CTL, 32'h2);
    wait_idle(2, "R6 done");
    rd(OCC, v); check("R6 occupancy", v, 3);
    for (int i = 0; i < 3; i++) begin
      rd(RDAT, v); check("R8 pop order", v, 32'hC0DE_0000 + 32'(exp_k)); exp_k++;
    end
    rd(RDAT, v); check("R8 empty pop", v, 0);
    rd(OCC, v); check("R8 empty occupancy", v, 0);
  endtask

  task automatic t_read_stall();
    logic [31:0] v;
    wr(SIZE, 6);
    wr(CTL, 32'h2);
    repeat (10) @(negedge clk);
    rd(OCC, v); check("R7 full occupancy", v, RD);
    rd(CTL, v); check("R7 still busy", v & 2, 2);
    check("R7 ready low", {31'b0, cfg_in_ready}, 0);
    for (int i = 0; i < 2; i++) begin
      rd(RDAT, v); check("R8 pop stall", v, 32'hC0DE_0000 + 32'(exp_k)); exp_k++;
    end
    wait_idle(2, "R7 resumed done");
    rd(OCC, v); check("R7 final occupancy", v, RD);
    for (int i = 0; i < RD; i++) begin
      rd(RDAT, v); check("R7 rest order", v, 32'hC0DE_0000 + 32'(exp_k)); exp_k++;
    end
    cfg_in_valid = 1'b0;
  endtask

  task automatic t_startup();
    logic [31:0] v;
    startup_done = 1'b1;
    rd(STAT, v); check("R9 startup bit", v, 32'h5);
    startup_done = 1'b0;
    rd(STAT, v); check("R9 startup cleared", v, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_push_drain();
    t_backpressure();
    t_overflow();
    t_readback();
    t_read_stall();
    t_startup();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule